// File: doc/BRIEF.md
# CAN Error and Overload Frame Sequencer

This block produces the bit stream a CAN node puts on the bus when it signals an error or an overload, together with the interframe space that follows. It advances once per bit, on a strobe from the bit timing logic. On every strobe it samples the bus level and the trigger inputs. The node's fault-confinement state is an input to the block, and it decides the polarity of an error flag: dominant for an error-active node, recessive for an error-passive node.

After the six-bit flag, the block keeps driving recessive and watches the bus. Other nodes may echo the flag, and the block tolerates that echo until the first recessive bit appears. It then counts out an eight-bit delimiter and a three-bit intermission.

During intermission, either a dominant bus bit or an internal not-ready request starts an overload frame. At most two overload frames may follow one another, and the allowance is restored by the next start of frame. An error-passive node that sent an error frame also waits for six consecutive recessive bus bits before it reports the bus idle.

Top module: `can_efs`

## Requirements
- R1: After reset, and whenever no frame activity is in progress, `tx_bit` is 1 (recessive), `busy` is 0 and `bus_idle` is 1. On `bus_idle`, a 0 on `rx_bit` at a strobe is taken as a start of frame: `bus_idle` drops and `busy` stays 0.
- R2: A strobe with `err_trig` high and `err_passive` low makes `tx_bit` 0 for the next six bit periods, with `busy` high.
- R3: A strobe with `err_trig` high and `err_passive` high gives a flag of six bit periods with `tx_bit` held at 1 and `busy` high.
- R4: After the flag, `tx_bit` is 1. Dominant bus bits sampled after the flag are tolerated while the dominant total, counting the six flag bits, stays at or below twelve. A thirteenth dominant bit starts a new error flag.
- R5: The first recessive bus bit sampled after the flag is the first of eight delimiter bits. A dominant bus bit sampled during the delimiter starts a new error flag.
- R6: After the delimiter comes an intermission of three recessive bits with `busy` high. The block then returns to bus idle, unless R7 applies.
- R7: After an error frame whose flag was recessive, the block stays busy after intermission until six consecutive recessive bus bits are sampled. A dominant bit restarts that count.
- R8: During intermission, a dominant bus bit or `ovl_req` at a strobe starts an overload flag. The overload flag is always six dominant bits, whatever `err_passive` is, and is followed by the same echo, delimiter and intermission handling.
- R9: At most two overload frames follow one another. Beyond that, `ovl_req` during intermission is ignored, and a dominant bit is taken as a start of frame (`busy` 0, `bus_idle` 0). A start of frame restores the allowance.
- R10: `ovl_req` has no effect outside intermission.
- R11: An error trigger during any phase, including an error or overload frame already in progress, restarts the six-bit flag at once.
- R12: All inputs are sampled, and the state changes, only on cycles with `bit_tick` high. On other cycles the outputs hold their values.
- R13: While a frame from another node is on the bus, `frame_end` at a strobe starts the three-bit intermission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_tick | input | 1 | One-cycle strobe per bit, at the sample point |
| rx_bit | input | 1 | Sampled bus level, 1 = recessive |
| err_trig | input | 1 | Bus error detected in the current bit |
| ovl_req | input | 1 | Internal not-ready request for an overload frame |
| frame_end | input | 1 | Last bit of a received or sent frame's end field |
| err_passive | input | 1 | Node is error-passive (1) or error-active (0) |
| tx_bit | output | 1 | Bit to transmit, 1 = recessive |
| busy | output | 1 | Error or overload frame, intermission or passive wait in progress |
| bus_idle | output | 1 | Bus considered idle |

## Verification
Every phase counter in this block shows up at `tx_bit`, `busy` or `bus_idle` within a few bit periods. A flag counter that is off by one changes the number of dominant bits seen on `tx_bit`. A wrong echo or delimiter count moves the strobe at which `busy` falls. A wrong overload budget shows up at the third dominant intermission bit: the block either starts another flag or lets the bus go to frame state. A lost passive-wait marker makes `bus_idle` rise up to six bit periods too early. The bench runs a bit-level reference model in step with the design and compares all three outputs after every strobe, and also while the strobe is low, so that any divergence is reported in the bit period where it first appears.

// File: rtl/can_efs_pkg.sv
package can_efs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FRAME  = 3'd1,
        ST_FLAG   = 3'd2,
        ST_ECHO   = 3'd3,
        ST_DELIM  = 3'd4,
        ST_INTERM = 3'd5,
        ST_SUSP   = 3'd6
    } efs_state_e;

    typedef struct packed {
        logic rx;
        logic err;
        logic ovl;
        logic fend;
    } efs_in_s;

    function automatic int cnt_width(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return $clog2(m + 1);
    endfunction

endpackage

// File: rtl/can_efs_ovl_budget.sv
module can_efs_ovl_budget #(
    parameter int OVL_MAX = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic take,
    input  logic clr,
    output logic room
);
    localparam int OW = $clog2(OVL_MAX + 1);
    localparam logic [OW-1:0] LIMIT = OW'(OVL_MAX);

    logic [OW-1:0] used_q;

    always_ff @(posedge clk) begin
        if (rst)       used_q <= '0;
        else if (clr)  used_q <= '0;
        else if (take) used_q <= used_q + 1'b1;
    end

    assign room = (used_q < LIMIT);

    // R9
    ovl_budget_chk: assert property (@(posedge clk) disable iff (rst)
        used_q <= LIMIT);

    // R9
    ovl_take_room_chk: assert property (@(posedge clk) disable iff (rst)
        take |-> room);
endmodule

// File: rtl/can_efs_seq.sv
module can_efs_seq
    import can_efs_pkg::*;
#(
    parameter int FLAG_BITS  = 6,
    parameter int ECHO_MAX   = 12,
    parameter int DELIM_BITS = 8,
    parameter int IFS_BITS   = 3,
    parameter int SUSP_BITS  = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  efs_in_s    bus_in,
    input  logic       passive,
    input  logic       ovl_room,
    output efs_state_e state,
    output logic       rec_flag,
    output logic       ovl_take,
    output logic       ovl_clr
);
    localparam int CW = cnt_width(ECHO_MAX, DELIM_BITS, IFS_BITS, SUSP_BITS);
    localparam logic [CW-1:0] FLAG_LAST  = CW'(FLAG_BITS - 1);
    localparam logic [CW-1:0] FLAG_TOTAL = CW'(FLAG_BITS);
    localparam logic [CW-1:0] ECHO_TOP   = CW'(ECHO_MAX);
    localparam logic [CW-1:0] DELIM_LAST = CW'(DELIM_BITS - 1);
    localparam logic [CW-1:0] IFS_LAST   = CW'(IFS_BITS - 1);
    localparam logic [CW-1:0] SUSP_LAST  = CW'(SUSP_BITS - 1);

    efs_state_e    st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          rec_q, rec_d;
    logic          pend_q, pend_d;
    logic          go_err;

    always_comb begin
        st_d     = st_q;
        cnt_d    = cnt_q;
        rec_d    = rec_q;
        pend_d   = pend_q;
        ovl_take = 1'b0;
        ovl_clr  = 1'b0;
        go_err   = tick & bus_in.err;
        if (tick && !bus_in.err) begin
            case (st_q)
                ST_IDLE: begin
                    if (!bus_in.rx) begin
                        st_d    = ST_FRAME;
                        ovl_clr = 1'b1;
                    end
                end
                ST_FRAME: begin
                    if (bus_in.fend) begin
                        st_d  = ST_INTERM;
                        cnt_d = '0;
                    end
                end
                ST_FLAG: begin
                    if (cnt_q == FLAG_LAST) begin
                        st_d  = ST_ECHO;
                        cnt_d = FLAG_TOTAL;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_ECHO: begin
                    if (bus_in.rx) begin
                        st_d  = ST_DELIM;
                        cnt_d = CW'(1);
                    end else if (cnt_q == ECHO_TOP) begin
                        go_err = 1'b1;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_DELIM: begin
                    if (!bus_in.rx) begin
                        go_err = 1'b1;
                    end else if (cnt_q == DELIM_LAST) begin
                        st_d  = ST_INTERM;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_INTERM: begin
                    if ((!bus_in.rx || bus_in.ovl) && ovl_room) begin
                        st_d     = ST_FLAG;
                        cnt_d    = '0;
                        rec_d    = 1'b0;
                        ovl_take = 1'b1;
                    end else if (!bus_in.rx) begin
                        st_d    = ST_FRAME;
                        pend_d  = 1'b0;
                        ovl_clr = 1'b1;
                    end else if (cnt_q == IFS_LAST) begin
                        st_d   = pend_q ? ST_SUSP : ST_IDLE;
                        pend_d = 1'b0;
                        cnt_d  = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_SUSP: begin
                    if (!bus_in.rx) begin
                        cnt_d = '0;
                    end else if (cnt_q == SUSP_LAST) begin
                        st_d  = ST_IDLE;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    st_d  = ST_IDLE;
                    cnt_d = '0;
                end
            endcase
        end
        if (go_err) begin
            st_d   = ST_FLAG;
            cnt_d  = '0;
            rec_d  = passive;
            pend_d = passive;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            rec_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            rec_q  <= rec_d;
            pend_q <= pend_d;
        end
    end

    assign state    = st_q;
    assign rec_flag = rec_q;

    // R2
    flag_len_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_FLAG) |-> (cnt_q < FLAG_TOTAL));

    // R4
    echo_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ECHO) |-> (cnt_q >= FLAG_TOTAL && cnt_q <= ECHO_TOP));

    // R5
    delim_range_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_DELIM) |-> (cnt_q != '0 && cnt_q <= DELIM_LAST));

    // R11
    err_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && bus_in.err) |=> (st_q == ST_FLAG && cnt_q == '0));

    // R12
    no_tick_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(st_q) && $stable(cnt_q));
endmodule

// File: rtl/can_efs_drive.sv
module can_efs_drive
    import can_efs_pkg::*;
(
    input  efs_state_e state,
    input  logic       rec_flag,
    output logic       tx_bit,
    output logic       busy,
    output logic       bus_idle
);
    always_comb begin
        tx_bit   = 1'b1;
        busy     = 1'b1;
        bus_idle = 1'b0;
        case (state)
            ST_IDLE:  begin busy = 1'b0; bus_idle = 1'b1; end
            ST_FRAME: busy = 1'b0;
            ST_FLAG:  tx_bit = rec_flag;
            default:  ;
        endcase
    end
endmodule

// File: rtl/can_efs.sv
module can_efs
    import can_efs_pkg::*;
#(
    parameter int FLAG_BITS  = 6,
    parameter int ECHO_MAX   = 12,
    parameter int DELIM_BITS = 8,
    parameter int IFS_BITS   = 3,
    parameter int SUSP_BITS  = 6,
    parameter int OVL_MAX    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_tick,
    input  logic rx_bit,
    input  logic err_trig,
    input  logic ovl_req,
    input  logic frame_end,
    input  logic err_passive,
    output logic tx_bit,
    output logic busy,
    output logic bus_idle
);
    efs_in_s    bus_in;
    efs_state_e state;
    logic       rec_flag, ovl_take, ovl_clr, ovl_room;

    assign bus_in = '{rx: rx_bit, err: err_trig, ovl: ovl_req, fend: frame_end};

    can_efs_seq #(
        .FLAG_BITS(FLAG_BITS), .ECHO_MAX(ECHO_MAX), .DELIM_BITS(DELIM_BITS),
        .IFS_BITS(IFS_BITS), .SUSP_BITS(SUSP_BITS)
    ) u_seq (
        .clk(clk), .rst(rst), .tick(bit_tick), .bus_in(bus_in),
        .passive(err_passive), .ovl_room(ovl_room), .state(state),
        .rec_flag(rec_flag), .ovl_take(ovl_take), .ovl_clr(ovl_clr)
    );

    can_efs_ovl_budget #(.OVL_MAX(OVL_MAX)) u_budget (
        .clk(clk), .rst(rst), .take(ovl_take), .clr(ovl_clr), .room(ovl_room)
    );

    can_efs_drive u_drive (
        .state(state), .rec_flag(rec_flag),
        .tx_bit(tx_bit), .busy(busy), .bus_idle(bus_idle)
    );

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        bus_idle |-> (tx_bit && !busy));

    // R1
    not_busy_recessive_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> tx_bit);
endmodule

// File: tb/can_efs_test.sv
module can_efs_test;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_tick = 1'b0, rx_bit = 1'b1, err_trig = 1'b0, ovl_req = 1'b0;
    logic frame_end = 1'b0, err_passive = 1'b0;
    logic tx_bit, busy, bus_idle;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // model: 0 idle 1 frame 2 flag 3 echo 4 delim 5 interm 6 susp
    int m_st = 0, m_n = 0, m_ovl = 0;
    bit m_rec = 0, m_pend = 0;

    always #10 clk = ~clk;

    can_efs uut (
        .clk(clk), .rst(rst), .bit_tick(bit_tick), .rx_bit(rx_bit),
        .err_trig(err_trig), .ovl_req(ovl_req), .frame_end(frame_end),
        .err_passive(err_passive), .tx_bit(tx_bit), .busy(busy), .bus_idle(bus_idle)
    );

    function automatic bit e_tx();   return (m_st == 2) ? m_rec : 1'b1; endfunction
    function automatic bit e_busy(); return m_st >= 2; endfunction
    function automatic bit e_idle(); return m_st == 0; endfunction

    function automatic string tag_of();
        case (m_st)
            0: return "R1";
            1: return "R13";
            2: return m_rec ? "R3" : "R2";
            3: return "R4";
            4: return "R5";
            5: return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string tag, input string what, input bit act, input bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        string t;
        t = (tag == "") ? tag_of() : tag;
        check(t, "tx_bit", tx_bit, e_tx());
        check(t, "busy", busy, e_busy());
        check(t, "bus_idle", bus_idle, e_idle());
    endtask

    task automatic start_err(input bit p);
        m_st = 2; m_n = 0; m_rec = p; m_pend = p;
    endtask

    task automatic model(input bit rx, input bit e, input bit o, input bit f, input bit p);
        if (e) begin
            start_err(p);
        end else begin
            case (m_st)
                0: if (!rx) begin m_st = 1; m_ovl = 0; end
                1: if (f) begin m_st = 5; m_n = 0; end
                2: begin
                    m_n++;
                    if (m_n == 6) begin m_st = 3; m_n = 6; end
                end
                3: begin
                    if (rx) begin m_st = 4; m_n = 1; end
                    else if (m_n + 1 > 12) start_err(p);
                    else m_n++;
                end
                4: begin
                    if (!rx) start_err(p);
                    else begin
                        m_n++;
                        if (m_n == 8) begin m_st = 5; m_n = 0; end
                    end
                end
                5: begin
                    if ((!rx || o) && m_ovl < 2) begin
                        m_st = 2; m_n = 0; m_rec = 0; m_ovl++;
                    end else if (!rx) begin
                        m_st = 1; m_pend = 0; m_ovl = 0;
                    end else begin
                        m_n++;
                        if (m_n == 3) begin m_st = m_pend ? 6 : 0; m_pend = 0; m_n = 0; end
                    end
                end
                default: begin
                    if (!rx) m_n = 0;
                    else begin
                        m_n++;
                        if (m_n == 6) begin m_st = 0; m_n = 0; end
                    end
                end
            endcase
        end
    endtask

    task automatic step(input bit rx, input bit e, input bit o, input bit f,
                        input bit p, input string tag);
        @(negedge clk);
        rx_bit = rx; err_trig = e; ovl_req = o; frame_end = f; err_passive = p;
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0; err_trig = 1'b0; ovl_req = 1'b0; frame_end = 1'b0;
        model(rx, e, o, f, p);
        check_all(tag);
    endtask

    // R12: cycles without a strobe, with noisy inputs, must not move anything
    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rx_bit = $urandom_range(0, 1);
            err_trig = $urandom_range(0, 1);
            ovl_req = $urandom_range(0, 1);
            frame_end = $urandom_range(0, 1);
            @(negedge clk);
            err_trig = 1'b0; ovl_req = 1'b0; frame_end = 1'b0;
            check_all("R12");
        end
    endtask

    task automatic bits(input int n, input bit rx, input string tag);
        for (int i = 0; i < n; i++) step(rx, 0, 0, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        void'($urandom(32'h5EED_C0DE));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // active error frame: flag, delimiter, intermission, idle
        step(1, 1, 0, 0, 0, "R2");
        bits(5, 0, "R2");
        bits(8, 1, "R5");
        bits(3, 1, "R6");
        gap(3);

        // echo up to twelve dominant bits accepted
        step(1, 1, 0, 0, 0, "R2");
        bits(5, 0, "R2");
        bits(6, 0, "R4");
        bits(8, 1, "R4");
        bits(3, 1, "R6");
        // thirteenth dominant bit starts a new flag
        step(1, 1, 0, 0, 0, "R2");
        bits(5, 0, "R2");
        bits(7, 0, "R4");
        bits(5, 0, "R4");
        bits(11, 1, "R4");
        // dominant bit inside the delimiter
        step(1, 1, 0, 0, 0, "R2");
        bits(5, 0, "R2");
        bits(3, 1, "R5");
        step(0, 0, 0, 0, 0, "R5");
        bits(5, 0, "R5");
        bits(11, 1, "R5");

        // passive frame with suspended wait
        step(1, 1, 0, 0, 1, "R3");
        bits(5, 1, "R3");
        bits(8, 1, "R3");
        bits(3, 1, "R7");
        bits(3, 1, "R7");
        step(0, 0, 0, 0, 0, "R7");
        bits(5, 1, "R7");
        step(1, 0, 0, 0, 0, "R7");
        check_all("R7");

        // overload chain, limit and restore
        step(1, 1, 0, 0, 0, "R2");
        bits(5, 0, "R2");
        bits(8, 1, "R5");
        step(0, 0, 0, 0, 1, "R8");
        bits(5, 1, "R8");
        bits(8, 1, "R8");
        step(1, 0, 1, 0, 1, "R8");
        bits(5, 1, "R8");
        bits(8, 1, "R8");
        step(1, 0, 1, 0, 0, "R9");
        step(0, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 1, 0, "R13");
        bits(3, 1, "R13");
        step(0, 0, 0, 0, 0, "R9");
        step(1, 0, 0, 1, 0, "R9");
        step(1, 0, 1, 0, 0, "R9");
        bits(5, 0, "R9");
        bits(11, 1, "R9");

        // request outside intermission, restart during flag
        step(1, 0, 1, 0, 0, "R10");
        step(1, 1, 0, 0, 0, "R10");
        step(0, 0, 1, 0, 0, "R10");
        step(0, 0, 0, 0, 0, "R11");
        step(1, 1, 0, 0, 1, "R11");
        bits(5, 1, "R11");
        bits(11, 1, "R11");
        bits(6, 1, "R7");

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            bit rx, e, o, f, p;
            rx = ($urandom_range(0, 99) < 70);
            e  = ($urandom_range(0, 99) < 3);
            o  = ($urandom_range(0, 99) < 8);
            f  = ($urandom_range(0, 99) < 10);
            p  = $urandom_range(0, 1);
            step(rx, e, o, f, p, "");
            if ($urandom_range(0, 9) == 0) gap(1);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule